// File: doc/BRIEF.md
# Multi-Phase Peak Detector

The block follows up to three signed sample streams, one per phase of a polyphase measurement. It keeps the largest magnitude seen on the phases chosen by a select mask, over a window measured in half line cycles. The window advances on the zero-crossing pulses of every selected phase. Selecting two phases therefore closes a window after half as many line periods as selecting one. One instance serves the current channel and a second serves the voltage channel.

When a window closes, the block loads a 32-bit result word. The low 24 bits hold the unsigned peak magnitude, and a one-hot field names the phase that produced it. The block also sets a sticky status flag. While that flag is set and enabled, an active-low interrupt line is held low. Filtering and the generation of the crossing pulses sit outside the block.

Top module: `phase_peak_tracker`

## Requirements
- R1: The peak is the largest absolute value of any selected sample within the window, including the sample of the closing cycle. It is written to result[23:0] as an unsigned number, so the input -8388608 yields 0x800000.
- R2: A window closes on the cycle whose selected crossing pulses bring the count since the last close to at least win_len. With one phase and a length of 16, it closes on the 16th pulse. A length of 0 behaves like 1.
- R3: Every crossing pulse of a selected phase adds one to the count, and simultaneous pulses add separately. Pulses of unselected phases add nothing. phase_sel bit 0 is phase A, bit 1 is B and bit 2 is C.
- R4: Samples of unselected phases never affect the peak, however large they are.
- R5: result[26:24] is a one-hot flag naming the winning phase: bit 24 for A, bit 25 for B, bit 26 for C. Each close replaces the previous flag. result[31:27] always reads zero.
- R6: When selected phases tie with equal magnitude in the same cycle, the lowest-numbered phase wins. A later sample that only equals the running maximum does not displace the winner already held.
- R7: result changes only on the cycle after a window closes, and otherwise holds its value.
- R8: The running maximum starts again from zero after each close, so a smaller peak in the next window is reported as it is.
- R9: status becomes 1 on the cycle after a close. A stat_clr pulse clears it on the next cycle. If a close and a clear arrive in the same cycle, the status is set.
- R10: irq_n is 0 exactly while status is 1 and irq_en is 1, and is 1 at all other times.
- R11: With phase_sel all zero, no window closes and result and status are left unchanged. A count already accumulated is kept for when phases are selected again.
- R12: After reset, result is 0, status is 0 and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp | input | 3x24 | Signed samples; samp[0] phase A, samp[1] B, samp[2] C |
| zc | input | 3 | Zero-crossing pulses, one bit per phase |
| phase_sel | input | 3 | Monitored phases mask |
| win_len | input | 8 | Window length in half line cycles |
| irq_en | input | 1 | Interrupt enable for the status flag |
| stat_clr | input | 1 | Write-one-to-clear pulse for status |
| result | output | 32 | {5'b0, phase flag[2:0], peak[23:0]} |
| status | output | 1 | Sticky window-closed flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The main function is driven with several patterns. A single selected phase with mixed-sign samples shows that the magnitude is tracked rather than the signed value. Alternating and simultaneous crossings on two phases show that each selected pulse shortens the window. Very large samples and crossing pulses on an unselected phase must leave both the peak and the count untouched. Equal magnitudes, within one cycle and across cycles, separate the tie rule from plain arrival order. A long window of 16 pulses checks the close point against the pulse before it. A large peak followed by a small one shows that the maximum restarts after each close. The most negative input checks the one magnitude that needs the full 24-bit range.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  localparam int unsigned PPT_SAMP_W = 24;
  localparam int unsigned PPT_NPH    = 3;
  localparam int unsigned PPT_LEN_W  = 8;
  localparam int unsigned PPT_RES_W  = 32;
endpackage

// File: rtl/ppt_mag.sv
// Magnitude of one two's-complement sample, returned as unsigned of the same width.
module ppt_mag #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] s_i,
  output logic [W-1:0] m_o
);
  always_comb begin
    if (s_i[W-1]) m_o = (~s_i) + {{(W-1){1'b0}}, 1'b1};
    else          m_o = s_i;
  end
endmodule

// File: rtl/ppt_win_ctr.sv
// Counts selected crossing pulses and flags the closing cycle of each window.
module ppt_win_ctr #(
  parameter int unsigned NPH   = 3,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPH-1:0]   zc_i,
  input  logic [NPH-1:0]   sel_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             end_o
);
  localparam int unsigned HIT_W = $clog2(NPH + 1);
  localparam int unsigned SUM_W = LEN_W + HIT_W;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [HIT_W-1:0] hits;
  logic [SUM_W-1:0] sum;

  always_comb begin
    hits = '0;
    for (int i = 0; i < NPH; i++) begin
      hits = hits + HIT_W'(zc_i[i] & sel_i[i]);
    end
  end

  always_comb begin
    sum   = SUM_W'(cnt_q) + SUM_W'(hits);
    end_o = (hits != '0) && (sum >= SUM_W'(len_i));
    cnt_d = cnt_q;
    if (end_o)             cnt_d = '0;
    else if (hits != '0)   cnt_d = sum[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppt_peak_track.sv
// Selects this cycle's strongest selected phase and folds it into the running maximum.
module ppt_peak_track #(
  parameter int unsigned W   = 24,
  parameter int unsigned NPH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPH-1:0][W-1:0] samp_i,
  input  logic [NPH-1:0]        sel_i,
  input  logic                  end_i,
  output logic [W-1:0]          peak_o,
  output logic [NPH-1:0]        flag_o
);
  logic [NPH-1:0][W-1:0] mag;
  logic [W-1:0]          cand_mag;
  logic [NPH-1:0]        cand_flag;
  logic                  cand_vld;
  logic [W-1:0]          run_max_q, run_max_d;
  logic [NPH-1:0]        run_flag_q, run_flag_d;
  logic                  take;

  for (genvar g = 0; g < NPH; g++) begin : g_mag
    ppt_mag #(.W(W)) mag_i (.s_i(samp_i[g]), .m_o(mag[g]));
  end

  // Ascending scan with a strict compare keeps the lowest phase on a tie.
  always_comb begin
    cand_mag  = '0;
    cand_flag = '0;
    cand_vld  = 1'b0;
    for (int i = 0; i < NPH; i++) begin
      if (sel_i[i] && (!cand_vld || (mag[i] > cand_mag))) begin
        cand_mag  = mag[i];
        cand_flag = '0;
        cand_flag[i] = 1'b1;
        cand_vld  = 1'b1;
      end
    end
  end

  always_comb begin
    take   = cand_vld && ((run_flag_q == '0) || (cand_mag > run_max_q));
    peak_o = take ? cand_mag  : run_max_q;
    flag_o = take ? cand_flag : run_flag_q;
    if (end_i) begin
      run_max_d  = '0;
      run_flag_d = '0;
    end else begin
      run_max_d  = peak_o;
      run_flag_d = flag_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_max_q  <= '0;
      run_flag_q <= '0;
    end else begin
      run_max_q  <= run_max_d;
      run_flag_q <= run_flag_d;
    end
  end
endmodule

// File: rtl/phase_peak_tracker.sv
module phase_peak_tracker
  import ppt_pkg::*;
#(
  parameter int unsigned SAMP_W = PPT_SAMP_W,
  parameter int unsigned NPH    = PPT_NPH,
  parameter int unsigned LEN_W  = PPT_LEN_W,
  parameter int unsigned RES_W  = PPT_RES_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPH-1:0][SAMP_W-1:0] samp,
  input  logic [NPH-1:0]             zc,
  input  logic [NPH-1:0]             phase_sel,
  input  logic [LEN_W-1:0]           win_len,
  input  logic                       irq_en,
  input  logic                       stat_clr,
  output logic [RES_W-1:0]           result,
  output logic                       status,
  output logic                       irq_n
);
  localparam int unsigned PAD_W = RES_W - NPH - SAMP_W;

  logic              win_end;
  logic [SAMP_W-1:0] peak;
  logic [NPH-1:0]    flag;
  logic [RES_W-1:0]  res_q, res_d;
  logic              stat_q, stat_d;

  ppt_win_ctr #(.NPH(NPH), .LEN_W(LEN_W)) win_i (
    .clk(clk), .rst_n(rst_n), .zc_i(zc), .sel_i(phase_sel),
    .len_i(win_len), .end_o(win_end)
  );

  ppt_peak_track #(.W(SAMP_W), .NPH(NPH)) trk_i (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .sel_i(phase_sel),
    .end_i(win_end), .peak_o(peak), .flag_o(flag)
  );

  always_comb begin
    res_d  = res_q;
    stat_d = stat_q;
    if (win_end) res_d = {{PAD_W{1'b0}}, flag, peak};
    if (win_end)       stat_d = 1'b1;
    else if (stat_clr) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      stat_q <= stat_d;
    end
  end

  assign result = res_q;
  assign status = stat_q;
  assign irq_n  = ~(stat_q & irq_en);
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  phase_sel,
  input logic        stat_clr,
  input logic        irq_en,
  input logic [31:0] result,
  input logic        status,
  input logic        irq_n,
  input logic        win_end
);
  p_flag_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(result[26:24]) && (result[31:27] == 5'd0));
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(result));
  p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> status);
  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !win_end) |=> !status);
  p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status && irq_en) |-> !irq_n);
  p_irq_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!status || !irq_en) |-> irq_n);
  p_no_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_sel == 3'b000) |-> !win_end);
endmodule

bind phase_peak_tracker ppt_checker chk_i (
  .clk(clk), .rst_n(rst_n), .phase_sel(phase_sel), .stat_clr(stat_clr),
  .irq_en(irq_en), .result(result), .status(status), .irq_n(irq_n),
  .win_end(win_end)
);

// File: tb/phase_peak_tracker_tb.sv
`timescale 1ns/1ps
module phase_peak_tracker_tb_top;
  logic             clk;
  logic             rst_n;
  logic [2:0][23:0] samp;
  logic [2:0]       zc;
  logic [2:0]       phase_sel;
  logic [7:0]       win_len;
  logic             irq_en;
  logic             stat_clr;
  logic [31:0]      result;
  logic             status;
  logic             irq_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  phase_peak_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .samp(samp), .zc(zc), .phase_sel(phase_sel),
    .win_len(win_len), .irq_en(irq_en), .stat_clr(stat_clr),
    .result(result), .status(status), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge; outputs are sampled at the next falling edge.
  task automatic step(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c,
                      input logic [2:0] z, input logic clr);
    samp[0] = a; samp[1] = b; samp[2] = c; zc = z; stat_clr = clr;
    @(negedge clk);
    zc = 3'b000; stat_clr = 1'b0; samp = '0;
  endtask

  task automatic t_reset;
    chk("R12 result", result, 32'h0);
    chk("R12 status", {31'b0, status}, 32'h0);
    chk("R12 irq_n", {31'b0, irq_n}, 32'h1);
  endtask

  task automatic t_basic;
    irq_en = 1'b1; phase_sel = 3'b001; win_len = 8'd2;
    step(24'd100, 0, 0, 3'b001, 1'b0);
    chk("R7 hold after first pulse", result, 32'h0);
    step(24'hFFFE0C, 0, 0, 3'b000, 1'b0);
    chk("R7 hold mid window", result, 32'h0);
    step(24'd200, 0, 0, 3'b001, 1'b0);
    chk("R1 magnitude peak", result, 32'h010001F4);
    chk("R9 status set", {31'b0, status}, 32'h1);
    chk("R10 irq low", {31'b0, irq_n}, 32'h0);
  endtask

  task automatic t_clear;
    step(0, 0, 0, 3'b000, 1'b1);
    chk("R9 status cleared", {31'b0, status}, 32'h0);
    chk("R10 irq released", {31'b0, irq_n}, 32'h1);
    chk("R7 result kept", result, 32'h010001F4);
  endtask

  task automatic t_two_phase;
    phase_sel = 3'b011; win_len = 8'd4;
    step(24'd10, 24'd900, 0, 3'b001, 1'b0);
    step(24'd10, 24'd5, 0, 3'b010, 1'b0);
    step(24'd10, 24'd5, 0, 3'b001, 1'b0);
    chk("R3 three pulses not enough", result, 32'h010001F4);
    step(24'd10, 24'd5, 0, 3'b010, 1'b0);
    chk("R3 R5 two phases close, B flag", result, 32'h02000384);
    win_len = 8'd2;
    step(24'd7, 24'd3, 0, 3'b011, 1'b0);
    chk("R3 R8 simultaneous pulses, restart", result, 32'h01000007);
  endtask

  task automatic t_unselected;
    phase_sel = 3'b001; win_len = 8'd2;
    step(24'd20, 0, 24'h7FFFFF, 3'b100, 1'b0);
    step(24'd30, 0, 24'h7FFFFF, 3'b001, 1'b0);
    chk("R3 unselected pulse ignored", result, 32'h01000007);
    step(24'd25, 0, 24'h800000, 3'b001, 1'b0);
    chk("R4 unselected sample ignored", result, 32'h0100001E);
  endtask

  task automatic t_ties;
    phase_sel = 3'b111; win_len = 8'd1;
    step(24'd1000, 24'hFFFC18, 24'd1000, 3'b001, 1'b0);
    chk("R6 same-cycle tie to A", result, 32'h010003E8);
    phase_sel = 3'b110; win_len = 8'd2;
    step(0, 24'd50, 0, 3'b010, 1'b0);
    step(0, 0, 24'd50, 3'b100, 1'b0);
    chk("R6 later equal keeps B", result, 32'h02000032);
  endtask

  task automatic t_most_negative;
    phase_sel = 3'b100; win_len = 8'd1;
    step(0, 0, 24'h800000, 3'b100, 1'b0);
    chk("R1 R5 most negative on C", result, 32'h04800000);
  endtask

  task automatic t_long;
    phase_sel = 3'b001; win_len = 8'd16;
    for (int i = 1; i <= 15; i++) step(24'(i), 0, 0, 3'b001, 1'b0);
    chk("R2 no close at 15", result, 32'h04800000);
    step(24'd16, 0, 0, 3'b001, 1'b0);
    chk("R2 close at 16", result, 32'h01000010);
    win_len = 8'd0;
    step(24'd9, 0, 0, 3'b001, 1'b0);
    chk("R2 zero length as one", result, 32'h01000009);
  endtask

  task automatic t_no_sel;
    step(0, 0, 0, 3'b000, 1'b1);
    phase_sel = 3'b001; win_len = 8'd2;
    step(24'h21, 0, 0, 3'b001, 1'b0);
    phase_sel = 3'b000;
    for (int i = 0; i < 3; i++) step(24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 3'b111, 1'b0);
    chk("R11 result unchanged", result, 32'h01000009);
    chk("R11 status unchanged", {31'b0, status}, 32'h0);
    phase_sel = 3'b001;
    step(24'd5, 0, 0, 3'b001, 1'b0);
    chk("R11 count kept", result, 32'h01000021);
  endtask

  task automatic t_irq_mask;
    irq_en = 1'b0;
    @(negedge clk);
    chk("R10 masked irq high", {31'b0, irq_n}, 32'h1);
    chk("R9 status still set", {31'b0, status}, 32'h1);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 unmasked irq low", {31'b0, irq_n}, 32'h0);
    step(0, 0, 0, 3'b000, 1'b1);
    win_len = 8'd1;
    step(24'd4, 0, 0, 3'b001, 1'b1);
    chk("R9 set wins over clear", {31'b0, status}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; samp = '0; zc = '0; phase_sel = '0; win_len = '0;
    irq_en = 1'b0; stat_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_two_phase();
    t_unselected();
    t_ties();
    t_most_negative();
    t_long();
    t_no_sel();
    t_irq_mask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule